// File: doc/BRIEF.md
# Phase-Synchronizable PWM Time-Base Counter

This block is the time-base counter of a PWM channel. It counts up, down or up and down against a programmable period. It advances only on cycles where the time-base enable is high, so a divided time-base clock is expressed as an enable on the fast clock. Its outputs are the counter value, the count direction, and flags for counter-at-zero and counter-at-period. Downstream compare and waveform logic uses them.

Any of four sources can raise a synchronization event:

- the external sync input;
- a software force-sync strobe;
- two digital-compare event inputs, each with its own enable.

When phase loading is enabled, the event reloads the counter with a programmed phase value on the next enabled edge. In up-down mode a configured direction bit then decides which way the counter runs, whatever the direction was before. Events that arrive while the enable is low are held until the next enabled edge.

A registered sync output pulse lets other counters be chained to this one. Its source is selectable: the combined sync events passed through, the counter at zero, the counter at a compare value, or off.

Top module: `pwm_timebase`

## Requirements
- R1: While rst_ni is low, cnt_o is 0, dir_o is 1 (counting up) and sync_o is 0.
- R2: With mode_i = 0 (up), each enabled edge increments cnt_o. When cnt_o is at or above period_i, the edge loads 0 instead.
- R3: With mode_i = 1 (down), each enabled edge decrements cnt_o. When cnt_o is 0, the edge loads period_i instead.
- R4: With mode_i = 2 or 3 (up-down), the counter counts up while dir_o = 1. At or above period_i it turns and counts down (dir_o = 0). At 0 it turns up again. In up mode dir_o reads 1, and in down mode it reads 0.
- R5: On a clock edge where tb_en_i is 0, cnt_o and the internal direction hold. A sync event seen in such a cycle is kept and acts on the next edge where tb_en_i is 1.
- R6: When phase_en_i is 1 and a sync event is pending or present at an enabled edge, cnt_o equals phase_i after that edge instead of the normal count step.
- R7: A one-cycle pulse on sw_sync_i has exactly the same effect as a pulse on sync_i. The strobe holds no state of its own beyond the pending event.
- R8: dc_evt_i[k] creates a sync event only when dc_en_i[k] is 1. A disabled compare event changes nothing.
- R9: In up-down mode, after a phase load, dir_o equals phase_dir_i (1 = up), independent of the prior direction.
- R10: In up or down mode, phase_dir_i is ignored: dir_o and the following count steps are unchanged by it.
- R11: When phase_en_i is 0, sync events do not alter counting. They still reach sync_o when pass-through is selected.
- R12: syncout_sel_i chooses the sync output source: 0 off, 1 combined sync event, 2 cnt_o == 0, 3 cnt_o == cmp_i. The condition is evaluated at an enabled edge, and sync_o is high for the clock cycle following that edge. It is never high after a non-enabled edge.
- R13: zero_o is 1 exactly when cnt_o is 0, and prd_o is 1 exactly when cnt_o equals period_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tb_en_i | input | 1 | Time-base enable; qualifies counting and sync handling |
| mode_i | input | 2 | 0 up, 1 down, 2/3 up-down |
| period_i | input | CNT_W | Period value |
| phase_i | input | CNT_W | Phase value loaded on sync |
| cmp_i | input | CNT_W | Compare value for the sync output source |
| phase_en_i | input | 1 | Enables phase loading on sync events |
| phase_dir_i | input | 1 | Direction after sync in up-down mode (1 = up) |
| sync_i | input | 1 | External sync input pulse |
| sw_sync_i | input | 1 | Software force-sync strobe |
| dc_evt_i | input | N_DC | Digital-compare event inputs |
| dc_en_i | input | N_DC | Per-event sync enable |
| syncout_sel_i | input | 2 | Sync output source select |
| cnt_o | output | CNT_W | Counter value |
| dir_o | output | 1 | Count direction (1 = up) |
| zero_o | output | 1 | Counter equals zero |
| prd_o | output | 1 | Counter equals period |
| sync_o | output | 1 | Registered sync output pulse |

## Verification
The assertions check on every cycle the following:

- the hold of the counter on non-enabled edges;
- the phase load after external or software sync;
- the wrap points of up and down mode when no load can interfere;
- the post-sync direction in up-down mode;
- the silence of sync_o after non-enabled edges or when it is switched off.

Only the bench's scenarios can show two things. The first is that a sync seen during disabled cycles is carried to the next enabled edge. The second is that disabled compare events and the direction bit in single-direction modes leave the count untouched, with the up-down reversal and the zero and compare sync sources tracked against a model under random mode, period and event traffic.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;
  typedef enum logic [1:0] {
    CM_UP   = 2'd0,
    CM_DOWN = 2'd1,
    CM_UPDN = 2'd2,
    CM_UPDX = 2'd3
  } cnt_mode_e;

  typedef enum logic [1:0] {
    SO_OFF  = 2'd0,
    SO_PASS = 2'd1,
    SO_ZERO = 2'd2,
    SO_CMP  = 2'd3
  } so_sel_e;

  function automatic logic is_updn(input cnt_mode_e m);
    return m[1];
  endfunction
endpackage

// File: rtl/pwm_tb_sync_gather.sv
module pwm_tb_sync_gather #(
  parameter int N_DC = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tb_en_i,
  input  logic            sync_i,
  input  logic            sw_sync_i,
  input  logic [N_DC-1:0] dc_evt_i,
  input  logic [N_DC-1:0] dc_en_i,
  output logic            sync_now_o
);
  logic [N_DC-1:0] dc_hit;
  logic            pend_q;
  logic            evt_now;

  for (genvar g = 0; g < N_DC; g++) begin : g_dc
    assign dc_hit[g] = dc_evt_i[g] & dc_en_i[g];
  end

  assign evt_now    = sync_i | sw_sync_i | (|dc_hit);
  assign sync_now_o = pend_q | evt_now;

  // events seen while the time base is stalled wait for the next enabled edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= 1'b0;
    else if (tb_en_i) pend_q <= 1'b0;
    else              pend_q <= sync_now_o;
  end
endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tb_en_i,
  input  cnt_mode_e        mode_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] phase_i,
  input  logic             load_i,
  input  logic             phase_dir_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] NONE = '0;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dir_q, dir_d;
  logic             at_top, at_zero;

  assign at_top  = (cnt_q >= period_i);
  assign at_zero = (cnt_q == NONE);

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    if (load_i) begin
      cnt_d = phase_i;
      if (is_updn(mode_i)) dir_d = phase_dir_i;
    end else begin
      unique case (mode_i)
        CM_UP:   cnt_d = at_top ? NONE : cnt_q + ONE;
        CM_DOWN: cnt_d = at_zero ? period_i : cnt_q - ONE;
        default: begin
          if (dir_q) begin
            if (at_top) begin
              dir_d = 1'b0;
              cnt_d = at_zero ? NONE : cnt_q - ONE;
            end else begin
              cnt_d = cnt_q + ONE;
            end
          end else begin
            if (at_zero) begin
              dir_d = 1'b1;
              cnt_d = (period_i == NONE) ? NONE : ONE;
            end else begin
              cnt_d = cnt_q - ONE;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
    end else if (tb_en_i) begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  always_comb begin
    unique case (mode_i)
      CM_UP:   dir_o = 1'b1;
      CM_DOWN: dir_o = 1'b0;
      default: dir_o = dir_q;
    endcase
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwm_tb_syncout.sv
module pwm_tb_syncout
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tb_en_i,
  input  so_sel_e          sel_i,
  input  logic             sync_now_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             sync_o
);
  logic fire;
  logic so_q;

  always_comb begin
    unique case (sel_i)
      SO_PASS: fire = sync_now_i;
      SO_ZERO: fire = (cnt_i == '0);
      SO_CMP:  fire = (cnt_i == cmp_i);
      default: fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) so_q <= 1'b0;
    else         so_q <= tb_en_i & fire;
  end

  assign sync_o = so_q;
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_DC  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tb_en_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] phase_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             phase_en_i,
  input  logic             phase_dir_i,
  input  logic             sync_i,
  input  logic             sw_sync_i,
  input  logic [N_DC-1:0]  dc_evt_i,
  input  logic [N_DC-1:0]  dc_en_i,
  input  logic [1:0]       syncout_sel_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             zero_o,
  output logic             prd_o,
  output logic             sync_o
);
  logic      sync_now;
  logic      load;
  cnt_mode_e mode;
  so_sel_e   so_sel;

  assign mode   = cnt_mode_e'(mode_i);
  assign so_sel = so_sel_e'(syncout_sel_i);
  assign load   = sync_now & phase_en_i;

  pwm_tb_sync_gather #(.N_DC(N_DC)) u_gather (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tb_en_i    (tb_en_i),
    .sync_i     (sync_i),
    .sw_sync_i  (sw_sync_i),
    .dc_evt_i   (dc_evt_i),
    .dc_en_i    (dc_en_i),
    .sync_now_o (sync_now)
  );

  pwm_tb_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tb_en_i     (tb_en_i),
    .mode_i      (mode),
    .period_i    (period_i),
    .phase_i     (phase_i),
    .load_i      (load),
    .phase_dir_i (phase_dir_i),
    .cnt_o       (cnt_o),
    .dir_o       (dir_o)
  );

  pwm_tb_syncout #(.CNT_W(CNT_W)) u_so (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tb_en_i    (tb_en_i),
    .sel_i      (so_sel),
    .sync_now_i (sync_now),
    .cnt_i      (cnt_o),
    .cmp_i      (cmp_i),
    .sync_o     (sync_o)
  );

  assign zero_o = (cnt_o == '0);
  assign prd_o  = (cnt_o == period_i);
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tb_en_i,
  input logic [1:0]       mode_i,
  input logic [CNT_W-1:0] period_i,
  input logic [CNT_W-1:0] phase_i,
  input logic             phase_en_i,
  input logic             phase_dir_i,
  input logic             sync_i,
  input logic             sw_sync_i,
  input logic [1:0]       syncout_sel_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             dir_o,
  input logic             sync_o
);
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tb_en_i |=> $stable(cnt_o)); // R5

  AST_LOAD_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tb_en_i && phase_en_i && (sync_i || sw_sync_i)) |=> cnt_o == $past(phase_i)); // R6

  AST_UP_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tb_en_i && !phase_en_i && mode_i == 2'd0 && cnt_o >= period_i) |=> cnt_o == '0); // R2

  AST_UP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tb_en_i && !phase_en_i && mode_i == 2'd0 && cnt_o < period_i)
    |=> cnt_o == $past(cnt_o) + CNT_W'(1)); // R11

  AST_DOWN_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tb_en_i && !phase_en_i && mode_i == 2'd1 && cnt_o == '0) |=> cnt_o == $past(period_i)); // R3

  AST_UPDN_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tb_en_i && phase_en_i && mode_i[1] && sync_i)
    |=> (!mode_i[1] || dir_o == $past(phase_dir_i))); // R9

  AST_SYNCO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tb_en_i |=> !sync_o); // R12

  AST_SYNCO_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (syncout_sel_i == 2'd0) |=> !sync_o); // R12

  AST_SYNCO_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tb_en_i && syncout_sel_i == 2'd1 && sync_i) |=> sync_o); // R11
endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tb_en_i       (tb_en_i),
  .mode_i        (mode_i),
  .period_i      (period_i),
  .phase_i       (phase_i),
  .phase_en_i    (phase_en_i),
  .phase_dir_i   (phase_dir_i),
  .sync_i        (sync_i),
  .sw_sync_i     (sw_sync_i),
  .syncout_sel_i (syncout_sel_i),
  .cnt_o         (cnt_o),
  .dir_o         (dir_o),
  .sync_o        (sync_o)
);

// File: tb/sim_pwm_timebase.sv
`timescale 1ns/1ps
module sim_pwm_timebase;
  localparam int W = 16;
  localparam int ND = 2;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          tb_en_i = 1'b1;
  logic [1:0]    mode_i = 2'd0;
  logic [W-1:0]  period_i = 16'd4;
  logic [W-1:0]  phase_i = '0;
  logic [W-1:0]  cmp_i = '0;
  logic          phase_en_i = 1'b0;
  logic          phase_dir_i = 1'b1;
  logic          sync_i = 1'b0;
  logic          sw_sync_i = 1'b0;
  logic [ND-1:0] dc_evt_i = '0;
  logic [ND-1:0] dc_en_i = '0;
  logic [1:0]    syncout_sel_i = 2'd0;
  logic [W-1:0]  cnt_o;
  logic          dir_o, zero_o, prd_o, sync_o;

  int n_chk = 0;
  int n_bad = 0;

  // reference state
  logic [W-1:0] m_cnt = '0;
  logic         m_dir = 1'b1;
  logic         m_pend = 1'b0;
  logic         m_so = 1'b0;

  always #10 clk = ~clk;

  pwm_timebase #(.CNT_W(W), .N_DC(ND)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tb_en_i(tb_en_i), .mode_i(mode_i),
    .period_i(period_i), .phase_i(phase_i), .cmp_i(cmp_i),
    .phase_en_i(phase_en_i), .phase_dir_i(phase_dir_i), .sync_i(sync_i),
    .sw_sync_i(sw_sync_i), .dc_evt_i(dc_evt_i), .dc_en_i(dc_en_i),
    .syncout_sel_i(syncout_sel_i), .cnt_o(cnt_o), .dir_o(dir_o),
    .zero_o(zero_o), .prd_o(prd_o), .sync_o(sync_o)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_dir();
    if (mode_i == 2'd0) return 1'b1;
    if (mode_i == 2'd1) return 1'b0;
    return m_dir;
  endfunction

  // reference: one enabled or stalled edge per the requirements
  task automatic model_step();
    logic pall;
    pall = m_pend | sync_i | sw_sync_i | (|(dc_evt_i & dc_en_i));
    if (tb_en_i) begin
      case (syncout_sel_i)
        2'd1:    m_so = pall;
        2'd2:    m_so = (m_cnt == '0);
        2'd3:    m_so = (m_cnt == cmp_i);
        default: m_so = 1'b0;
      endcase
      if (pall && phase_en_i) begin
        m_cnt = phase_i;
        if (mode_i[1]) m_dir = phase_dir_i;
      end else if (mode_i == 2'd0) begin
        m_cnt = (m_cnt >= period_i) ? '0 : m_cnt + 1'b1;
      end else if (mode_i == 2'd1) begin
        m_cnt = (m_cnt == '0) ? period_i : m_cnt - 1'b1;
      end else if (m_dir) begin
        if (m_cnt >= period_i) begin
          m_dir = 1'b0;
          if (m_cnt != '0) m_cnt = m_cnt - 1'b1;
        end else m_cnt = m_cnt + 1'b1;
      end else begin
        if (m_cnt == '0) begin
          m_dir = 1'b1;
          if (period_i != '0) m_cnt = 16'd1;
        end else m_cnt = m_cnt - 1'b1;
      end
      m_pend = 1'b0;
    end else begin
      m_pend = pall;
      m_so   = 1'b0;
    end
  endtask

  task automatic compare_all();
    string ct;
    ct = (mode_i == 2'd0) ? "R2" : (mode_i == 2'd1) ? "R3" : "R4";
    check(ct, cnt_o, m_cnt);
    check("R4 dir", W'(dir_o), W'(exp_dir()));
    check("R13 zero", W'(zero_o), W'(m_cnt == '0));
    check("R13 prd", W'(prd_o), W'(m_cnt == period_i));
    check("R12 sync_o", W'(sync_o), W'(m_so));
  endtask

  // inputs are set at a negedge, then one clock passes
  task automatic tick();
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  logic [W-1:0] prev;

  initial begin : watchdog
    #(20 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 cnt", cnt_o, '0);
    check("R1 dir", W'(dir_o), W'(1));
    check("R1 sync_o", W'(sync_o), '0);
    rst_ni = 1'b1;

    // up mode, period 4: 0 1 2 3 4 0
    for (int i = 0; i < 4; i++) tick();
    check("R13 prd at 4", W'(prd_o), W'(1));
    tick();
    check("R2 wrap", cnt_o, '0);

    // stalled sync is kept until the next enabled edge
    phase_en_i = 1'b1; phase_i = 16'd9;
    tb_en_i = 1'b0; sync_i = 1'b1; tick();
    check("R5 hold", cnt_o, '0);
    sync_i = 1'b0; tick();
    check("R5 still held", cnt_o, '0);
    tb_en_i = 1'b1; tick();
    check("R5 deferred load", cnt_o, 16'd9);
    tick();
    check("R2 above period wraps", cnt_o, '0);

    // software force
    phase_i = 16'd3; sw_sync_i = 1'b1; tick();
    sw_sync_i = 1'b0;
    check("R7 sw load", cnt_o, 16'd3);
    tick();
    check("R7 no residue", cnt_o, 16'd4);

    // compare events gated by enables
    phase_i = 16'd2;
    prev = cnt_o; dc_evt_i = 2'b01; dc_en_i = 2'b10; tick();
    check("R8 disabled evt", cnt_o, (prev >= period_i) ? '0 : prev + 1'b1);
    dc_evt_i = 2'b10; tick();
    check("R8 enabled evt", cnt_o, 16'd2);
    dc_evt_i = 2'b00; dc_en_i = 2'b00;

    // up-down: direction after sync from phase_dir_i
    mode_i = 2'd2; period_i = 16'd10; phase_i = 16'd5;
    for (int i = 0; i < 3; i++) tick();
    phase_dir_i = 1'b0; sync_i = 1'b1; tick();
    sync_i = 1'b0;
    check("R9 load", cnt_o, 16'd5);
    check("R9 dir down", W'(dir_o), '0);
    tick();
    check("R9 counting down", cnt_o, 16'd4);
    for (int i = 0; i < 5; i++) tick();
    check("R4 turn at zero", W'(dir_o), W'(1));

    // up mode ignores phase_dir_i
    mode_i = 2'd0; phase_dir_i = 1'b0; phase_i = 16'd6; sync_i = 1'b1; tick();
    sync_i = 1'b0;
    check("R10 dir", W'(dir_o), W'(1));
    tick();
    check("R10 step", cnt_o, 16'd7);

    // no load when disabled, but pass-through still fires
    phase_en_i = 1'b0; syncout_sel_i = 2'd1;
    prev = cnt_o; sync_i = 1'b1; tick();
    sync_i = 1'b0;
    check("R11 no load", cnt_o, prev + 1'b1);
    check("R11 pass sync_o", W'(sync_o), W'(1));
    tick();
    check("R12 one cycle", W'(sync_o), '0);

    // zero source
    syncout_sel_i = 2'd2; period_i = 16'd3;
    for (int i = 0; i < 8; i++) tick();

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      tb_en_i   = ($urandom % 100) < 80;
      sync_i    = ($urandom % 100) < 5;
      sw_sync_i = ($urandom % 100) < 3;
      dc_evt_i  = ND'($urandom % 4) & ((($urandom % 100) < 15) ? 2'b11 : 2'b00);
      if (($urandom % 100) < 3) dc_en_i = ND'($urandom % 4);
      if (($urandom % 100) < 1) mode_i = 2'($urandom % 4);
      if (($urandom % 100) < 1) period_i = W'($urandom % 16);
      if (($urandom % 100) < 4) phase_i = W'($urandom % 21);
      if (($urandom % 100) < 3) cmp_i = W'($urandom % 16);
      if (($urandom % 100) < 2) syncout_sel_i = 2'($urandom % 4);
      if (($urandom % 100) < 2) phase_en_i = ~phase_en_i;
      phase_dir_i = 1'($urandom % 2);
      tick();
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule